// File: doc/BRIEF.md
# Codec Status and Interrupt Register

This block is the status register that a voice codec shows to its host microcontroller. It holds three event flags: store finished, play finished and page power ready. It also holds a five-bit power reading that the encoder produces at the end of each 1024-bit page. The command decoder in front of it sends single-cycle strobes when the host loads a store command, loads a play command, issues the general reset, or reads the status byte. The read-status command is code 61H, and the status comes back as one reply byte.

Each flag has its own clear rule. A command-complete flag stays up through any number of status reads. It drops only when the next command of its own kind is loaded. The power-ready flag drops on a status read. An interrupt request line is raised by any of the three events while interrupts are enabled, and a status read takes it down.

The reply byte is a snapshot taken on the read strobe. It does not follow the live flags. An event in the same cycle as a read is not lost: it is left set for the next read.

Top module: `codec_stat_reg`

## Requirements
- R1: After reset the reply byte is 00h and the interrupt line is low.
- R2: Reply byte layout: bit 7 is page power ready, bit 6 is store complete, bit 5 is play complete, and bits 4..0 hold the power reading.
- R3: The store-complete flag sets on a store-done pulse. It stays set through status reads and clears only on a load-store strobe or on general reset.
- R4: The play-complete flag sets on a play-done pulse. It stays set through status reads and clears only on a load-play strobe or on general reset.
- R5: The power-ready flag sets on every page-end pulse and clears on a status read.
- R6: The power field takes `power_in` on a page-end pulse and holds that value otherwise, including across reads.
- R7: A store-done, play-done or page-end pulse raises the interrupt line on the next cycle only while `irq_en` is high. With `irq_en` low, no interrupt is raised.
- R8: A status read lowers the interrupt line on the next cycle.
- R9: On a read strobe the reply byte captures the flags and the power field as they stood before that cycle's updates. Between reads the reply byte does not change.
- R10: When a set event and a clear event hit the same flag, or the interrupt, in the same cycle, the set wins.
- R11: General reset clears all three flags, the power field and the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 1 | Interrupt enable from the control register |
| store_done | input | 1 | Pulse: store command finished |
| play_done | input | 1 | Pulse: play command finished |
| page_end | input | 1 | Pulse: encoder page finished, `power_in` valid |
| power_in | input | PWR_W | Power reading for the finished page |
| load_store | input | 1 | Strobe: new store command loaded |
| load_play | input | 1 | Strobe: new play command loaded |
| gen_reset | input | 1 | Strobe: general reset command |
| rd_stb | input | 1 | Strobe: status read |
| status_byte | output | PWR_W+3 | Reply byte captured at the last read |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands in the same cycle as the read or clear that competes with it. In that cycle the reply must show the old state while the flag and the interrupt stay set. The stimulus drives a page-end pulse in the same cycle as a read strobe, and a store-done pulse in the same cycle as a load-store strobe. Follow-up reads then show that the set survived and that the snapshot was taken before the update.

// File: rtl/codec_stat_pkg.sv
package codec_stat_pkg;
    localparam int NFLAG     = 3;
    // flag index order fixes the reply byte layout (index 2 is the MSB)
    localparam int FLG_PLAY  = 0;
    localparam int FLG_STORE = 1;
    localparam int FLG_PWR   = 2;
endpackage

// File: rtl/codec_stat_flag.sv
module codec_stat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.flag;

    // R10: set dominates a clear in the same cycle
    a_r10_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R3 R4 R5: a clear without a set drops the flag
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R3 R4: with no event the flag holds
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/codec_stat_pwr.sv
module codec_stat_pwr #(
    parameter int PWR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PWR_W-1:0] val_i,
    input  logic             clr_i,
    output logic [PWR_W-1:0] q_o
);
    typedef struct packed {
        logic [PWR_W-1:0] level;
    } pwr_st_t;

    pwr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)  st_d.level = '0;
        if (load_i) st_d.level = val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.level;

    // R6: a page end captures the reading
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(val_i)));
    // R6: without page end or reset the reading holds
    a_r6_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/codec_stat_irq.sv
module codec_stat_irq #(
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_i,
    input  logic           en_i,
    input  logic           ack_i,
    input  logic           clr_i,
    output logic           irq_o
);
    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    raise;

    always_comb begin
        raise = (|ev_i) && en_i;
        st_d  = st_q;
        if (ack_i || clr_i) st_d.pend = 1'b0;
        if (raise)          st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pend;

    // R7: the line only rises after an enabled event
    a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|ev_i) && en_i));
    // R8: a read with no competing enabled event lowers the line
    a_r8_read_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !((|ev_i) && en_i)) |=> !irq_o);
    // R11: general reset with no enabled event lowers the line
    a_r11_reset_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !((|ev_i) && en_i)) |=> !irq_o);
endmodule

// File: rtl/codec_stat_reg.sv
module codec_stat_reg
    import codec_stat_pkg::*;
#(
    parameter int PWR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_en,
    input  logic               store_done,
    input  logic               play_done,
    input  logic               page_end,
    input  logic [PWR_W-1:0]   power_in,
    input  logic               load_store,
    input  logic               load_play,
    input  logic               gen_reset,
    input  logic               rd_stb,
    output logic [PWR_W+2:0]   status_byte,
    output logic               irq
);
    localparam int STAT_W = PWR_W + NFLAG;

    typedef struct packed {
        logic [STAT_W-1:0] reply;
    } reply_st_t;

    logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
    logic [PWR_W-1:0] power_q;
    reply_st_t        rep_d, rep_q;

    always_comb begin
        flag_set           = '0;
        flag_clr           = '0;
        flag_set[FLG_PLAY]  = play_done;
        flag_set[FLG_STORE] = store_done;
        flag_set[FLG_PWR]   = page_end;
        flag_clr[FLG_PLAY]  = load_play  | gen_reset;
        flag_clr[FLG_STORE] = load_store | gen_reset;
        flag_clr[FLG_PWR]   = rd_stb     | gen_reset;
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            codec_stat_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (flag_set[i]),
                .clr_i (flag_clr[i]),
                .q_o   (flag_q[i])
            );
        end
    endgenerate

    codec_stat_pwr #(.PWR_W(PWR_W)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (page_end),
        .val_i  (power_in),
        .clr_i  (gen_reset),
        .q_o    (power_q)
    );

    codec_stat_irq #(.NEV(NFLAG)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (flag_set),
        .en_i  (irq_en),
        .ack_i (rd_stb),
        .clr_i (gen_reset),
        .irq_o (irq)
    );

    always_comb begin
        rep_d = rep_q;
        if (rd_stb) rep_d.reply = {flag_q, power_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign status_byte = rep_q.reply;

    // R9: a read captures the pre-update flags and power field
    a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (status_byte == $past({flag_q, power_q})));
    // R9: the reply does not move between reads
    a_r9_reply_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(status_byte));
    // R3: a read alone never drops the store flag
    a_r3_read_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && flag_q[FLG_STORE] && !load_store && !gen_reset) |=> flag_q[FLG_STORE]);
    // R4: a read alone never drops the play flag
    a_r4_read_keeps_play: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && flag_q[FLG_PLAY] && !load_play && !gen_reset) |=> flag_q[FLG_PLAY]);
endmodule

// File: tb/codec_stat_reg_test.sv
module codec_stat_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_en = 1'b0;
    logic       store_done = 1'b0, play_done = 1'b0, page_end = 1'b0;
    logic [4:0] power_in = '0;
    logic       load_store = 1'b0, load_play = 1'b0, gen_reset = 1'b0, rd_stb = 1'b0;
    logic [7:0] status_byte;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    codec_stat_reg uut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .store_done(store_done), .play_done(play_done), .page_end(page_end),
        .power_in(power_in), .load_store(load_store), .load_play(load_play),
        .gen_reset(gen_reset), .rd_stb(rd_stb),
        .status_byte(status_byte), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_drives();
        store_done = 0; play_done = 0; page_end = 0;
        load_store = 0; load_play = 0; gen_reset = 0; rd_stb = 0;
    endtask

    // driver: queue the expected reply, then pulse the read strobe
    task automatic read_expect(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_stb = 1;
        tick();
        clear_drives();
    endtask

    task automatic pulse_tick();
        tick();
        clear_drives();
    endtask

    // monitor: after each read edge compare the reply against the queue
    initial begin
        forever begin
            @(posedge clk);
            if (rd_stb) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected read", status_byte, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(status_byte == e, t, status_byte, e);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        check(status_byte == 8'h00, "R1 reply after reset", status_byte, 0);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        read_expect(8'h00, "R1 first read");

        irq_en = 1;
        store_done = 1; pulse_tick();
        check(irq == 1'b1, "R7 irq on store done", irq, 1);
        read_expect(8'h40, "R2 R3 store flag at bit 6");
        check(irq == 1'b0, "R8 read lowers irq", irq, 0);
        read_expect(8'h40, "R3 store flag survives read");
        load_store = 1; pulse_tick();
        read_expect(8'h00, "R3 load store clears flag");

        page_end = 1; power_in = 5'h13; pulse_tick();
        read_expect(8'h93, "R5 R6 power ready and value");
        read_expect(8'h13, "R5 read clears ready, R6 value held");

        play_done = 1; pulse_tick();
        read_expect(8'h33, "R4 play flag at bit 5");
        read_expect(8'h33, "R4 play flag survives read");
        load_play = 1; pulse_tick();
        read_expect(8'h13, "R4 load play clears flag");

        irq_en = 0;
        play_done = 1; pulse_tick();
        check(irq == 1'b0, "R7 no irq when disabled", irq, 0);
        irq_en = 1;

        page_end = 1; power_in = 5'h05;
        read_expect(8'h33, "R9 snapshot before same-cycle page end");
        check(irq == 1'b1, "R10 irq set wins over read", irq, 1);
        read_expect(8'hA5, "R10 ready set wins over read clear");
        check(irq == 1'b0, "R8 irq lowered", irq, 0);

        store_done = 1; load_store = 1; pulse_tick();
        read_expect(8'h65, "R10 store set wins over load");

        play_done = 1; pulse_tick();
        check(irq == 1'b1, "R7 irq before general reset", irq, 1);
        gen_reset = 1; pulse_tick();
        check(irq == 1'b0, "R11 general reset lowers irq", irq, 0);
        read_expect(8'h00, "R11 general reset clears flags and power");

        page_end = 1; power_in = 5'h1F; pulse_tick();
        tick();
        check(status_byte == 8'h00, "R9 reply holds between reads", status_byte, 0);
        read_expect(8'h9F, "R6 full-scale power reading");

        repeat (3) tick();
        check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule